// File: doc/BRIEF.md
# E1 CRC-4 Block Checker with Far-End Error Reporting

The block checks an E1 receive stream that is already aligned to its 16-frame multiframe. Each multiframe holds two sub-multiframes of eight frames each. For each sub-multiframe the block runs a four-bit cyclic remainder over every received bit. It then checks that remainder against the four check bits carried in the following sub-multiframe. A block that fails the check raises a one-cycle error pulse. It also adds one entry to a small pending-report counter.

The transmitter has two far-end report slots per multiframe, in bit 1 of frames 13 and 15. At each slot the block supplies the value to send. The value is zero when a report is pending, and each zero consumes one report. The block also counts checked blocks in fixed windows, 1000 blocks by default. At the end of each window it sets or clears a degradation flag, depending on whether the errored-block count reached the threshold, 915 by default.

The framer supplies a lock flag, a bit strobe, a frame-start strobe and the frame number within the multiframe. When the lock drops, all checker state is cleared.

Top module: `e1_crc4_chk`

## Requirements
- R1: While `rst_n` is low and after it is released, `ebit_stb_o`, `blk_err_o` and `thr_flag_o` are 0 and `ebit_val_o` is 1.
- R2: The remainder is the division remainder by x^4 + x + 1 of the sub-multiframe bits, taken in arrival order with each bit counted once per `bit_stb_i`, after multiplication by x^4. A sub-multiframe starts at the bit with `frm_stb_i` high and `frm_num_i` equal to 0 or 8. The check-bit positions count as zero. A check-bit position is the bit with `frm_stb_i` high in an even-numbered frame.
- R3: The check bits of sub-multiframe k are taken from frames 0, 2, 4 and 6 of that half, in that order, with the first one as the most significant. They are compared with the remainder of sub-multiframe k-1. On a mismatch, `blk_err_o` is high for exactly the one cycle after the first bit of sub-multiframe k+1.
- R4: `ebit_stb_o` pulses for one cycle after the bit with `frm_stb_i` high in frame 13 or 15, and at no other time.
- R5: Each errored block produces exactly one `ebit_val_o` of 0 on an `ebit_stb_o` pulse. All other pulses carry 1. Consecutive errored blocks give consecutive zero slots, and up to 2^PEND_W-1 reports are held.
- R6: When no earlier report is pending, an error is reported in the first report slot after its detection.
- R7: At every WINDOW-th checked block, `thr_flag_o` is set to whether the window held at least THRESH errored blocks. THRESH-1 errored blocks give 0. The flag holds its value until the next window end.
- R8: A window that reaches THRESH sets the flag. This includes the case where the window's final block is the one that reaches the threshold.
- R9: While `mf_lock_i` is low, the flag, the window counters, the pending reports and the check history are cleared. After lock returns, no check is made at the first two sub-multiframe starts.
- R10: Cycles with `bit_stb_i` low change no state, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mf_lock_i | input | 1 | Multiframe alignment held by the framer |
| bit_stb_i | input | 1 | A received bit is present this cycle |
| frm_stb_i | input | 1 | The present bit is bit 1 of a frame |
| frm_num_i | input | 4 | Frame number within the multiframe, 0 to 15 |
| rx_bit_i | input | 1 | Received data bit |
| ebit_stb_o | output | 1 | A report-slot value is ready |
| ebit_val_o | output | 1 | Value to send in the report slot (0 = errored block) |
| blk_err_o | output | 1 | One-cycle pulse for each errored block |
| thr_flag_o | output | 1 | Errored-block threshold reached in the last window |

## Verification
The window-end decision and an errored-block detection can land in the same cycle. This happens when the last block of a window fails its check. The bench arranges for the 915th error of a window to fall on block 1000 of that window, and for the other window to hold exactly 914 errors. It then expects the flag to be set only where the final errored block is included in the count. In the same cycle, that block's error pulse and its pending far-end report are checked against the scoreboard.

// File: rtl/e1_crc4_pkg.sv
package e1_crc4_pkg;

    localparam int CRC_W      = 4;
    localparam int FNUM_W     = 4;
    localparam int SMF_FRAMES = 8;

    // low terms of x^4 + x + 1
    localparam logic [CRC_W-1:0] POLY_LOW = 4'b0011;

    typedef struct packed {
        logic             started;   // a sub-multiframe start was seen since lock
        logic             prev_ok;   // prev_rem holds a complete remainder
        logic [CRC_W-1:0] prev_rem;
        logic [CRC_W-1:0] c_rx;
        logic             err;
    } smf_st_t;

    function automatic logic [CRC_W-1:0] crc_shift(input logic [CRC_W-1:0] r,
                                                   input logic d);
        logic fb;
        fb = d ^ r[CRC_W-1];
        crc_shift = {r[CRC_W-2:0], 1'b0} ^ (fb ? POLY_LOW : '0);
    endfunction

endpackage

// File: rtl/crc4_engine.sv
module crc4_engine
    import e1_crc4_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             step_i,
    input  logic             restart_i,
    input  logic             din_i,
    output logic [CRC_W-1:0] rem_o
);

    logic [CRC_W-1:0] rem_d, rem_q;

    always_comb begin
        rem_d = rem_q;
        if (clr_i) begin
            rem_d = '0;
        end else if (restart_i) begin
            rem_d = crc_shift('0, din_i);
        end else if (step_i) begin
            rem_d = crc_shift(rem_q, din_i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rem_q <= '0;
        else        rem_q <= rem_d;
    end

    // remainder of all bits before the present one
    assign rem_o = rem_q;

endmodule

// File: rtl/ebit_queue.sv
module ebit_queue #(
    parameter int PEND_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic add_i,
    input  logic slot_i,
    output logic ebit_stb_o,
    output logic ebit_val_o
);

    localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

    typedef struct packed {
        logic [PEND_W-1:0] pend;
        logic              stb;
        logic              val;
    } q_st_t;

    localparam q_st_t Q_IDLE = '{pend: '0, stb: 1'b0, val: 1'b1};

    q_st_t q_d, q_q;
    logic  take;

    always_comb begin
        q_d     = q_q;
        q_d.stb = 1'b0;
        take    = slot_i && (q_q.pend != '0);
        if (clr_i) begin
            q_d = Q_IDLE;
        end else begin
            if (slot_i) begin
                q_d.stb = 1'b1;
                q_d.val = (q_q.pend == '0);
            end
            if (add_i && !take) begin
                if (q_q.pend != PEND_MAX) q_d.pend = q_q.pend + 1'b1;
            end else if (!add_i && take) begin
                q_d.pend = q_q.pend - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= Q_IDLE;
        else        q_q <= q_d;
    end

    assign ebit_stb_o = q_q.stb;
    assign ebit_val_o = q_q.val;

endmodule

// File: rtl/err_window.sv
module err_window #(
    parameter int WINDOW = 1000,
    parameter int THRESH = 915
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic blk_i,
    input  logic bad_i,
    output logic flag_o
);

    localparam int CNT_W = $clog2(WINDOW + 1);
    localparam logic [CNT_W-1:0] LAST_BLK = CNT_W'(WINDOW - 1);
    localparam logic [CNT_W-1:0] LIMIT    = CNT_W'(THRESH);

    typedef struct packed {
        logic [CNT_W-1:0] blk;
        logic [CNT_W-1:0] bad;
        logic             flag;
    } w_st_t;

    w_st_t            w_d, w_q;
    logic [CNT_W-1:0] tot;

    always_comb begin
        w_d = w_q;
        tot = w_q.bad + CNT_W'(bad_i);
        if (clr_i) begin
            w_d = '0;
        end else if (blk_i) begin
            if (w_q.blk == LAST_BLK) begin
                w_d.flag = (tot >= LIMIT);
                w_d.blk  = '0;
                w_d.bad  = '0;
            end else begin
                w_d.blk = w_q.blk + 1'b1;
                w_d.bad = tot;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign flag_o = w_q.flag;

endmodule

// File: rtl/e1_crc4_chk.sv
module e1_crc4_chk
    import e1_crc4_pkg::*;
#(
    parameter int WINDOW = 1000,
    parameter int THRESH = 915,
    parameter int PEND_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mf_lock_i,
    input  logic              bit_stb_i,
    input  logic              frm_stb_i,
    input  logic [FNUM_W-1:0] frm_num_i,
    input  logic              rx_bit_i,
    output logic              ebit_stb_o,
    output logic              ebit_val_o,
    output logic              blk_err_o,
    output logic              thr_flag_o
);

    localparam int SMF_SEL_W = $clog2(SMF_FRAMES);

    logic             at_bit, at_smf, at_cbit, at_eslot;
    logic             crc_din, cmp_vld, cmp_bad, unlocked;
    logic [CRC_W-1:0] rem;
    smf_st_t          s_d, s_q;

    assign unlocked = !mf_lock_i;
    assign at_bit   = mf_lock_i && bit_stb_i;
    assign at_smf   = at_bit && frm_stb_i && (frm_num_i[SMF_SEL_W-1:0] == '0);
    assign at_cbit  = at_bit && frm_stb_i && !frm_num_i[0];
    assign at_eslot = at_bit && frm_stb_i &&
                      ((frm_num_i == 4'd13) || (frm_num_i == 4'd15));
    assign crc_din  = rx_bit_i && !at_cbit;

    crc4_engine u_crc (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (unlocked),
        .step_i    (at_bit),
        .restart_i (at_smf),
        .din_i     (crc_din),
        .rem_o     (rem)
    );

    assign cmp_vld = at_smf && s_q.prev_ok;
    assign cmp_bad = cmp_vld && (s_q.c_rx != s_q.prev_rem);

    always_comb begin
        s_d     = s_q;
        s_d.err = 1'b0;
        if (unlocked) begin
            s_d = '0;
        end else begin
            if (at_cbit) s_d.c_rx = {s_q.c_rx[CRC_W-2:0], rx_bit_i};
            if (at_smf) begin
                s_d.err     = cmp_bad;
                s_d.started = 1'b1;
                if (s_q.started) begin
                    s_d.prev_rem = rem;
                    s_d.prev_ok  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    ebit_queue #(.PEND_W(PEND_W)) u_eq (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (unlocked),
        .add_i      (cmp_bad),
        .slot_i     (at_eslot),
        .ebit_stb_o (ebit_stb_o),
        .ebit_val_o (ebit_val_o)
    );

    err_window #(.WINDOW(WINDOW), .THRESH(THRESH)) u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (unlocked),
        .blk_i  (cmp_vld),
        .bad_i  (cmp_bad),
        .flag_o (thr_flag_o)
    );

    assign blk_err_o = s_q.err;

endmodule

// File: rtl/e1_crc4_chk_sva.sv
module e1_crc4_chk_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       mf_lock_i,
    input logic       bit_stb_i,
    input logic       frm_stb_i,
    input logic [3:0] frm_num_i,
    input logic       ebit_stb_o,
    input logic       blk_err_o,
    input logic       thr_flag_o
);

    AST_ESTB_AT_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        ebit_stb_o |-> $past(mf_lock_i && bit_stb_i && frm_stb_i &&
                             (frm_num_i == 4'd13 || frm_num_i == 4'd15))); // R4

    AST_ERR_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        blk_err_o |-> $past(mf_lock_i && bit_stb_i && frm_stb_i &&
                            frm_num_i[2:0] == 3'd0)); // R3

    AST_UNLOCK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !mf_lock_i |=> (!thr_flag_o && !blk_err_o && !ebit_stb_o)); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_stb_i |=> (!blk_err_o && !ebit_stb_o)); // R10

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mf_lock_i && !(bit_stb_i && frm_stb_i && frm_num_i[2:0] == 3'd0))
        |=> $stable(thr_flag_o)); // R7

    AST_NO_ERR_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mf_lock_i) |-> !blk_err_o); // R9

endmodule

bind e1_crc4_chk e1_crc4_chk_sva u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .mf_lock_i  (mf_lock_i),
    .bit_stb_i  (bit_stb_i),
    .frm_stb_i  (frm_stb_i),
    .frm_num_i  (frm_num_i),
    .ebit_stb_o (ebit_stb_o),
    .blk_err_o  (blk_err_o),
    .thr_flag_o (thr_flag_o)
);

// File: tb/test_e1_crc4_chk.sv
module test_e1_crc4_chk;

    localparam int FB     = 4;     // bits per frame in the bench stream
    localparam int WINDOW = 1000;
    localparam int THRESH = 915;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       mf_lock, bit_stb, frm_stb, rx_bit;
    logic [3:0] frm_num;
    logic       ebit_stb_o, ebit_val_o, blk_err_o, thr_flag_o;

    always #4 clk = ~clk;

    e1_crc4_chk #(.WINDOW(WINDOW), .THRESH(THRESH), .PEND_W(3)) i_e1_crc4_chk (
        .clk        (clk),
        .rst_n      (rst_n),
        .mf_lock_i  (mf_lock),
        .bit_stb_i  (bit_stb),
        .frm_stb_i  (frm_stb),
        .frm_num_i  (frm_num),
        .rx_bit_i   (rx_bit),
        .ebit_stb_o (ebit_stb_o),
        .ebit_val_o (ebit_val_o),
        .blk_err_o  (blk_err_o),
        .thr_flag_o (thr_flag_o)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    // reference model state
    bit [3:0]  m_cur, m_prev;
    bit        m_started, m_pv, m_smf_bad, exp_flag, gap_en;
    int        m_frame, m_pend, m_cmp_w, m_bad_w;
    int        exp_err_total = 0;
    int        seen_err_total = 0;
    bit        exp_e_q[$];
    bit [15:0] lfsr = 16'hACE1;

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    function automatic bit [3:0] crc_add(bit [3:0] r, bit d);
        bit [4:0] x;
        x = {r, 1'b0};
        if (x[4] ^ d) x = x ^ 5'b10011;
        return x[3:0];
    endfunction

    function bit rnd();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    // drive one bit; model the expected outcome per the requirements
    task automatic put_bit(bit b, bit fs, int fn);
        bit bnd, cmp, wend, exp_e, first;
        bnd = fs && (fn % 8 == 0);
        cmp = 0; wend = 0; exp_e = 0; first = 0;
        if (bnd) begin
            if (m_pv) begin
                cmp   = 1;
                exp_e = m_smf_bad;
                if (exp_e) begin
                    m_pend++;
                    exp_err_total++;
                    m_bad_w++;
                end
                m_cmp_w++;
                if (m_cmp_w == WINDOW) begin
                    wend     = 1;
                    exp_flag = (m_bad_w >= THRESH);
                    m_cmp_w  = 0;
                    m_bad_w  = 0;
                end
            end else begin
                first = 1;
            end
            if (m_started) begin
                m_pv   = 1;
                m_prev = m_cur;
            end
            m_started = 1;
            m_cur     = '0;
        end
        m_cur = crc_add(m_cur, (fs && (fn % 2 == 0)) ? 1'b0 : b);
        if (fs && (fn == 13 || fn == 15)) begin
            exp_e_q.push_back(m_pend == 0);
            if (m_pend > 0) m_pend--;
        end
        mf_lock = 1; bit_stb = 1; frm_stb = fs; frm_num = 4'(fn); rx_bit = b;
        @(negedge clk);
        if (cmp)   check(blk_err_o == exp_e, "R3", "block error pulse", blk_err_o, exp_e);
        if (first) check(blk_err_o == 1'b0, "R9", "no check after relock", blk_err_o, 0);
        if (wend)  check(thr_flag_o == exp_flag, exp_flag ? "R8" : "R7",
                         "window flag", thr_flag_o, exp_flag);
        if (gap_en && rnd()) begin
            // R10: idle cycle with misleading side inputs
            bit_stb = 0; frm_stb = 1; frm_num = 4'd13; rx_bit = rnd();
            @(negedge clk);
        end
    endtask

    // one sub-multiframe; bad flips the first check bit
    task automatic send_smf(bit bad);
        bit [3:0] cval;
        cval = m_cur;
        for (int f = 0; f < 8; f++) begin
            int fn;
            fn = m_frame;
            for (int j = 0; j < FB; j++) begin
                bit b;
                if (j == 0 && (fn % 2 == 0)) begin
                    int idx;
                    idx = (fn % 8) / 2;
                    b = cval[3 - idx] ^ (bad && idx == 0);
                end else begin
                    b = rnd();
                end
                put_bit(b, j == 0, fn);
            end
            m_frame = (m_frame + 1) % 16;
        end
        m_smf_bad = bad;
    endtask

    task automatic unlock();
        mf_lock = 0; bit_stb = 0; frm_stb = 0; frm_num = '0; rx_bit = 0;
        repeat (2) @(negedge clk);
        check(thr_flag_o == 1'b0, "R9", "flag after lock loss", thr_flag_o, 0);
        check(blk_err_o == 1'b0, "R9", "error pulse after lock loss", blk_err_o, 0);
        m_started = 0; m_pv = 0; m_pend = 0; m_cmp_w = 0; m_bad_w = 0;
        m_frame = 0; m_cur = '0; exp_flag = 0;
    endtask

    // scoreboard monitor for report slots and error pulses
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (ebit_stb_o) begin
                if (exp_e_q.size() == 0) begin
                    check(0, "R4", "report strobe with no slot", 1, 0);
                end else begin
                    bit e;
                    e = exp_e_q.pop_front();
                    check(ebit_val_o == e, "R5", "report slot value", ebit_val_o, e);
                end
            end
            if (blk_err_o) seen_err_total++;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        rst_n = 0; mf_lock = 0; bit_stb = 0; frm_stb = 0; frm_num = '0; rx_bit = 0;
        m_started = 0; m_pv = 0; m_pend = 0; m_cmp_w = 0; m_bad_w = 0;
        m_frame = 0; m_cur = '0; m_prev = '0; m_smf_bad = 0; exp_flag = 0; gap_en = 0;
        repeat (3) @(negedge clk);
        check(ebit_stb_o == 0 && blk_err_o == 0 && thr_flag_o == 0, "R1",
              "outputs in reset", {ebit_stb_o, blk_err_o, thr_flag_o}, 0);
        check(ebit_val_o == 1, "R1", "report value in reset", ebit_val_o, 1);
        rst_n = 1;
        @(negedge clk);
        check(ebit_stb_o == 0 && blk_err_o == 0 && thr_flag_o == 0, "R1",
              "outputs after reset", {ebit_stb_o, blk_err_o, thr_flag_o}, 0);

        // R2 R10: clean stream with idle gaps, all checks pass, all slots 1
        gap_en = 1;
        repeat (6) send_smf(0);
        // R6: single errored block reported at next slot
        send_smf(1);
        repeat (4) send_smf(0);
        // R5: two consecutive errored blocks give two zero slots
        send_smf(1); send_smf(1);
        repeat (4) send_smf(0);
        // R5: longer burst
        repeat (6) send_smf(1);
        repeat (4) send_smf(0);
        gap_en = 0;
        unlock();

        // R7 R8: window with 914 errors, then one with 915 ending on an error
        for (int k = 0; k <= 2001; k++) begin
            send_smf(((k >= 87) && (k <= 1000)) || ((k >= 1086) && (k <= 2000)));
        end
        repeat (2) send_smf(0);
        check(thr_flag_o == 1'b1, "R7", "flag held between window ends", thr_flag_o, 1);
        unlock();

        // R9: relock, first checks skipped, clean afterwards
        repeat (4) send_smf(0);
        mf_lock = 1; bit_stb = 0;
        repeat (8) @(negedge clk);
        check(exp_e_q.size() == 0, "R5", "report slots left unserved", exp_e_q.size(), 0);
        check(seen_err_total == exp_err_total, "R3", "total error pulses",
              seen_err_total, exp_err_total);
        finish_run();
    end

endmodule